// File: doc/BRIEF.md
# Prioritized CPU Interrupt Dispatcher

The dispatcher sits between a small 8-bit processor core and a set of peripheral interrupt sources. Each source raises a one-cycle request pulse that latches into a flag register. The core masks the sources through an enable register. Both registers are read and written by the core through a simple select/write port. When at least one latched request is also enabled, the dispatcher raises `wake`, which ends the core's low-power halt. It does this whatever the state of the master enable.

The core reports every instruction boundary on `instr_done`. It also reports, at that boundary, whether the retiring instruction was an enable-interrupts or disable-interrupts instruction. The dispatcher decides at each boundary whether an interrupt is taken. It serves the lowest-numbered pending source. It emits a one-cycle `take_irq` pulse together with the vector address and the extra cycle cost of the call, then clears the served flag and the master enable. Stack handling and program-counter loading remain in the core.

Top module: `irq_dispatcher`

## Requirements
- R1: After reset, the flag register reads 0xE0, the enable register reads 0x00, `take_irq` and `wake` are low, and the master enable is off.
- R2: The flag register is selected by `reg_sel`=0. Its bits 7..5 always read as 1 and ignore writes, and bits 4..0 hold the written value.
- R3: The enable register is selected by `reg_sel`=1. It stores and returns all 8 written bits, but only bits 4..0 gate requests.
- R4: A pulse on `src_req[i]` sets flag bit i on the next clock edge. If a core write to the flag register happens in the same cycle, the set wins over a written 0.
- R5: `wake` is high exactly when some bit i in 0..4 is set in both the flag and the enable register, independent of the master enable.
- R6: An interrupt is taken only at a cycle with `instr_done` high, the master enable effective, a pending enabled request, and neither `ime_set` nor `ime_clr` asserted. `take_irq` is then high for exactly the following cycle.
- R7: Among pending enabled requests, the lowest bit index i wins. The vector is 0x40 + 8*i (0x40, 0x48, 0x50, 0x58, 0x60).
- R8: Taking an interrupt clears only the served flag bit and turns the master enable off, so the next boundary takes nothing.
- R9: `ime_set` at a boundary takes no interrupt at that boundary. The master enable becomes effective at the next boundary.
- R10: `ime_clr` at a boundary turns the master enable off, including an enable that was armed but not yet effective.
- R11: `extra_cycles` is 12 while `take_irq` is high and 0 otherwise. `vector` holds its value at all times except at a take.
- R12: With the master enable off, a pending enabled request keeps `wake` high, produces no take, and leaves its flag bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 5 | Peripheral request pulses, bit i = source i |
| reg_sel | input | 1 | Register select: 0 flag, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| instr_done | input | 1 | Instruction boundary strobe from the core |
| ime_set | input | 1 | Retiring instruction enables interrupts |
| ime_clr | input | 1 | Retiring instruction disables interrupts |
| take_irq | output | 1 | One-cycle take request |
| vector | output | 8 | Call address of the taken interrupt |
| extra_cycles | output | 8 | Added cycle cost of the take |
| wake | output | 1 | Ends the halt state |

## Verification
Single requests on each of the five lines confirm the full vector table. Simultaneous requests on bits 0 and 2 and on bits 3 and 4 show that the lowest index is served first, and that the loser stays latched for a later take. Requests with the master enable off, armed-then-cleared, or masked by the enable register separate the wake condition from the take condition. A request that collides with a clearing flag write shows which of the two wins.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic {
    SEL_FLAG   = 1'b0,
    SEL_ENABLE = 1'b1
  } irqd_sel_e;
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            sel,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] clr_mask,
  output logic [DW-1:0]   rdata,
  output logic [NSRC-1:0] flag_o,
  output logic [NSRC-1:0] en_o
);
  import irqd_pkg::*;
  localparam int PADW = DW - NSRC;

  logic [NSRC-1:0] flag_q, flag_d;
  logic [DW-1:0]   en_q, en_d;
  logic            flag_ld, en_ld;

  always_comb begin
    flag_ld = wr_en && (sel == SEL_FLAG);
    en_ld   = wr_en && (sel == SEL_ENABLE);
    flag_d  = flag_ld ? wdata[NSRC-1:0] : flag_q;
    flag_d  = flag_d & ~clr_mask;
    flag_d  = flag_d | src_req;
    en_d    = en_ld ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_ld) en_q <= en_d;
    end
  end

  generate
    if (PADW > 0) begin : g_pad
      assign rdata = (sel == SEL_FLAG) ? {{PADW{1'b1}}, flag_q} : en_q;
    end else begin : g_nopad
      assign rdata = (sel == SEL_FLAG) ? flag_q[DW-1:0] : en_q;
    end
  endgenerate

  assign flag_o = flag_q;
  assign en_o   = en_q[NSRC-1:0];
endmodule

// File: rtl/irqd_arb.sv
module irqd_arb #(
  parameter int          NSRC     = 5,
  parameter int          DW       = 8,
  parameter logic [7:0]  VEC_BASE = 8'h40,
  parameter int          VEC_STEP = 8
) (
  input  logic [NSRC-1:0] req,
  output logic            any,
  output logic [NSRC-1:0] grant,
  output logic [DW-1:0]   vec
);
  logic [NSRC:0] lower;
  logic [DW-1:0] vec_part [NSRC];

  assign lower[0] = 1'b0;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
      localparam logic [DW-1:0] VADDR = DW'(int'(VEC_BASE) + VEC_STEP * i);
      assign grant[i]    = req[i] & ~lower[i];
      assign lower[i+1]  = lower[i] | req[i];
      assign vec_part[i] = grant[i] ? VADDR : '0;
    end
  endgenerate

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++) vec = vec | vec_part[i];
  end

  assign any = lower[NSRC];
endmodule

// File: rtl/irqd_mstr.sv
module irqd_mstr (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic en_req,
  input  logic dis_req,
  input  logic take,
  output logic open_o,
  output logic ime_on,
  output logic ime_armed
);
  logic ime_q, ime_d, arm_q, arm_d;

  assign open_o = boundary && (ime_q || arm_q) && !en_req && !dis_req;

  always_comb begin
    ime_d = ime_q;
    arm_d = arm_q;
    if (take) begin
      ime_d = 1'b0;
      arm_d = 1'b0;
    end else if (boundary && dis_req) begin
      ime_d = 1'b0;
      arm_d = 1'b0;
    end else if (boundary && en_req) begin
      arm_d = 1'b1;
    end else if (boundary && arm_q) begin
      ime_d = 1'b1;
      arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      ime_q <= ime_d;
      arm_q <= arm_d;
    end
  end

  assign ime_on    = ime_q;
  assign ime_armed = arm_q;
endmodule

// File: rtl/irq_dispatcher.sv
module irq_dispatcher #(
  parameter int         NSRC        = 5,
  parameter int         DW          = 8,
  parameter logic [7:0] VEC_BASE    = 8'h40,
  parameter int         VEC_STEP    = 8,
  parameter int         CYW         = 8,
  parameter int         TAKE_CYCLES = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            instr_done,
  input  logic            ime_set,
  input  logic            ime_clr,
  output logic            take_irq,
  output logic [DW-1:0]   vector,
  output logic [CYW-1:0]  extra_cycles,
  output logic            wake
);
  logic [NSRC-1:0] flag, en, pend, grant, clr_mask;
  logic [DW-1:0]   arb_vec, vec_q;
  logic            any, open, take_now, take_q;
  logic            ime_on, ime_armed;

  irqd_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .src_req(src_req), .clr_mask(clr_mask),
    .rdata(reg_rdata), .flag_o(flag), .en_o(en)
  );

  assign pend = flag & en;

  irqd_arb #(.NSRC(NSRC), .DW(DW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .req(pend), .any(any), .grant(grant), .vec(arb_vec)
  );

  irqd_mstr u_mstr (
    .clk(clk), .rst_n(rst_n), .boundary(instr_done), .en_req(ime_set),
    .dis_req(ime_clr), .take(take_now), .open_o(open),
    .ime_on(ime_on), .ime_armed(ime_armed)
  );

  assign take_now = open && any;
  assign clr_mask = take_now ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= VEC_BASE;
    end else begin
      take_q <= take_now;
      if (take_now) vec_q <= arb_vec;
    end
  end

  assign take_irq     = take_q;
  assign vector       = vec_q;
  assign extra_cycles = take_q ? CYW'(TAKE_CYCLES) : '0;
  assign wake         = any;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int         NSRC        = 5,
  parameter int         DW          = 8,
  parameter logic [7:0] VEC_BASE    = 8'h40,
  parameter int         VEC_STEP    = 8,
  parameter int         CYW         = 8,
  parameter int         TAKE_CYCLES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           instr_done,
  input logic           ime_set,
  input logic           ime_clr,
  input logic           take_irq,
  input logic [DW-1:0]  vector,
  input logic [CYW-1:0] extra_cycles,
  input logic           wake,
  input logic           ime_on,
  input logic           ime_armed
);
  localparam int VMAX = int'(VEC_BASE) + VEC_STEP * (NSRC - 1);

  a_r6_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(instr_done) && !$past(ime_set) && !$past(ime_clr));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq);

  a_r5_wake_before_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(wake));

  a_r7_vector_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (int'(vector) >= int'(VEC_BASE)) && (int'(vector) <= VMAX)
                 && (((int'(vector) - int'(VEC_BASE)) % VEC_STEP) == 0));

  a_r8_ime_off_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !ime_on && !ime_armed);

  a_r12_no_take_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && !ime_on && !ime_armed) |=> !take_irq);

  a_r11_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> $stable(vector));

  a_r11_cost_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> extra_cycles == '0);
endmodule

bind irq_dispatcher irqd_checker #(
  .NSRC(NSRC), .DW(DW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP),
  .CYW(CYW), .TAKE_CYCLES(TAKE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ime_set(ime_set),
  .ime_clr(ime_clr), .take_irq(take_irq), .vector(vector),
  .extra_cycles(extra_cycles), .wake(wake), .ime_on(ime_on),
  .ime_armed(ime_armed)
);

// File: tb/test_irq_dispatcher.sv
module test_irq_dispatcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_req = '0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       instr_done = 1'b0;
  logic       ime_set = 1'b0;
  logic       ime_clr = 1'b0;
  logic       take_irq;
  logic [7:0] vector;
  logic [7:0] extra_cycles;
  logic       wake;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  irq_dispatcher i_irq_dispatcher (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .instr_done(instr_done), .ime_set(ime_set), .ime_clr(ime_clr),
    .take_irq(take_irq), .vector(vector), .extra_cycles(extra_cycles),
    .wake(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected takes, flags any unexpected one.
  always @(negedge clk) begin
    if (rst_n) begin
      if (take_irq) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6: actual take vector 0x%0h expected no take", vector);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check("R7 vector", vector, e);
          check("R11 cycles", extra_cycles, 12);
        end
      end else if (extra_cycles != 0) begin
        check("R11 idle cycles", extra_cycles, 0);
      end
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d, input logic [4:0] rq);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d; src_req = rq;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; src_req = '0;
  endtask

  task automatic pulse(input logic [4:0] rq);
    src_req = rq;
    @(posedge clk); @(negedge clk);
    src_req = '0;
  endtask

  task automatic rd(input logic sel, input string req, input int exp);
    reg_sel = sel; #1;
    check(req, reg_rdata, exp);
  endtask

  // Boundary: optional push of an expected take before it happens.
  task automatic bnd(input logic s, input logic c, input bit exp_take, input logic [7:0] v);
    if (exp_take) exp_q.push_back(v);
    instr_done = 1'b1; ime_set = s; ime_clr = c;
    @(posedge clk); @(negedge clk);
    instr_done = 1'b0; ime_set = 1'b0; ime_clr = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, "R1 flag", 8'hE0);
    rd(1'b1, "R1 enable", 8'h00);
    check("R1 wake", wake, 0);
    check("R1 take", take_irq, 0);

    wr(1'b0, 8'hFF, 5'h00); rd(1'b0, "R2 flag all", 8'hFF);
    wr(1'b0, 8'h0A, 5'h00); rd(1'b0, "R2 flag part", 8'hEA);
    wr(1'b0, 8'h00, 5'h00); rd(1'b0, "R2 flag clear", 8'hE0);
    wr(1'b1, 8'hA5, 5'h00); rd(1'b1, "R3 enable", 8'hA5);
    check("R3 upper bits no gate", wake, 0);
    wr(1'b1, 8'h1F, 5'h00); rd(1'b1, "R3 enable low", 8'h1F);

    pulse(5'h04); rd(1'b0, "R4 set", 8'hE4);
    check("R5 wake ime off", wake, 1);
    bnd(1'b0, 1'b0, 0, 8'h00);
    bnd(1'b0, 1'b0, 0, 8'h00);
    rd(1'b0, "R12 flag kept", 8'hE4);
    check("R12 wake kept", wake, 1);

    wr(1'b0, 8'h04, 5'h01); rd(1'b0, "R4 set beats clear", 8'hE5);

    bnd(1'b1, 1'b0, 0, 8'h00);             // R9: none at the enabling boundary
    bnd(1'b0, 1'b0, 1, 8'h40);             // R7 bit0 first
    rd(1'b0, "R8 served cleared", 8'hE4);
    bnd(1'b0, 1'b0, 0, 8'h00);             // R8 ime now off
    bnd(1'b1, 1'b0, 0, 8'h00);
    bnd(1'b0, 1'b0, 1, 8'h50);
    rd(1'b0, "R8 flag empty", 8'hE0);
    check("R5 wake low", wake, 0);

    pulse(5'h18);
    bnd(1'b1, 1'b0, 0, 8'h00);
    bnd(1'b0, 1'b0, 1, 8'h58);
    rd(1'b0, "R8 bit4 left", 8'hF0);
    bnd(1'b1, 1'b0, 0, 8'h00);
    bnd(1'b0, 1'b0, 1, 8'h60);

    pulse(5'h02);
    bnd(1'b1, 1'b0, 0, 8'h00);
    bnd(1'b0, 1'b1, 0, 8'h00);             // R10 armed enable cancelled
    bnd(1'b0, 1'b0, 0, 8'h00);
    rd(1'b0, "R10 flag kept", 8'hE2);

    wr(1'b1, 8'h00, 5'h00);
    check("R5 masked no wake", wake, 0);
    bnd(1'b1, 1'b0, 0, 8'h00);
    bnd(1'b0, 1'b0, 0, 8'h00);             // masked: ime becomes on, no take
    wr(1'b1, 8'h02, 5'h00);
    check("R5 unmasked wake", wake, 1);
    bnd(1'b0, 1'b0, 1, 8'h48);             // R6 take with ime held on
    rd(1'b0, "R8 flag empty again", 8'hE0);

    repeat (3) @(negedge clk);
    check("R6 all expected takes seen", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule